// File: doc/BRIEF.md
# In-Order Issue Hazard Interlock

This block sits at the issue point of a single-issue, in-order pipeline and decides each cycle whether the instruction offered on its input may leave or must wait. Every instruction carries an operation class, up to two source register numbers, a destination register number and a branch-taken flag. The interlock remembers which register was last written, by which class of producer and how many cycles ago. From that it computes how many more cycles the waiting instruction must hold. The hold depends on the producer/consumer class pair and comes from a fixed latency table, not from one uniform forwarding rule.

Floating-point and integer registers are tracked in two separate scoreboards. A taken conditional branch costs one flushed cycle after it unless delay-slot mode is on. In delay-slot mode the next instruction issues straight into the slot. The block brings out a ready signal for the instruction handshake, a stall flag, the remaining stall count and a two-bit per-cycle trace. The trace lets a testbench add up whole schedules.

Class codes on `in_class` are: 0 FP load, 1 FP store, 2 FP ALU, 3 integer ALU, 4 conditional branch. Trace codes are: 0 idle, 1 issue, 2 stall, 3 flush.

Top module: `issue_interlock`

## Requirements
- R1: After reset, `in_ready` is 1, `flush_o` is 0, `trace` is 0 (idle) and `stall_cnt` is 0. The first instruction issues without waiting.
- R2: An FP ALU op (class 2) reading an FP register written by an FP ALU op issued on the previous cycle waits 3 cycles.
- R3: An FP store (class 1) whose data source `in_src2` is an FP register written by the previous FP ALU op waits 2 cycles.
- R4: An FP ALU op reading the FP destination of the previous FP load (class 0) waits 1 cycle.
- R5: An FP store whose data is the FP destination of the previous FP load waits 0 cycles.
- R6: An integer ALU result (class 3) read on the next cycle by any integer source costs 1 stall cycle. Integer sources are: both sources of classes 3 and 4, and `in_src1` of classes 0 and 1 (the base).
- R7: Each cycle that passes after a producer issues, whether idle, issuing or stalled, lowers the stall it imposes by one, down to 0.
- R8: The FP and integer files are independent: FP register n never delays a read of integer register n, and the reverse also holds. Integer register 0 never creates a dependency.
- R9: Write-after-read and write-after-write add no stall. The most recent writer of a register alone sets the stall.
- R10: When both sources are pending, the wait equals the larger of the two remaining stalls.
- R11: With `delay_slot_en` at 0, the cycle after a taken branch (class 4, `in_taken` 1) issues is a flush cycle: `flush_o` is 1, `trace` is 3 and `in_ready` is 0. A not-taken branch causes no flush.
- R12: With `delay_slot_en` at 1, a taken branch causes no flush, and the next independent instruction issues on the following cycle.
- R13: While an instruction is held, `stall_cnt` shows its remaining wait and drops by one each stalled cycle, and `trace` is 2.
- R14: The unscheduled five-instruction loop takes 10 cycles per iteration, counting its flush. The loop is: FP load, dependent FP add, store of the sum, base decrement, taken branch on the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| delay_slot_en | input | 1 | 1: instruction after a taken branch fills its slot, no flush |
| in_valid | input | 1 | An instruction is offered |
| in_class | input | 3 | Operation class code |
| in_src1 | input | 5 | First source register (base for loads and stores) |
| in_src2 | input | 5 | Second source register (data for stores) |
| in_dst | input | 5 | Destination register |
| in_taken | input | 1 | Branch resolves taken |
| in_ready | output | 1 | Instruction may issue this cycle |
| stall_o | output | 1 | Valid instruction held by a hazard |
| stall_cnt | output | 2 | Remaining stall cycles of the offered instruction |
| flush_o | output | 1 | Branch slot flushed this cycle |
| trace | output | 2 | Per-cycle event: idle, issue, stall, flush |

## Verification
On every cycle, the assertions check these behaviours:
- a held instruction's stall count drops by exactly one while its fields stay put;
- a taken branch without delay-slot mode is followed by exactly one flush cycle;
- integer register 0 never becomes busy;
- a freshly written scoreboard entry starts at age zero.

The latency values of each producer/consumer pair only show up in the bench's scenarios. The same holds for the effect of idle gaps, the separation of the two register files, the maximum over two sources, the overriding by the latest writer and the ten-cycle loop total. The bench sweeps every producer class against every consumer class and gap length.

// File: rtl/iil_pkg.sv
package iil_pkg;

  localparam int LAT_W = 2;

  typedef enum logic [2:0] {
    IC_FP_LD   = 3'd0,
    IC_FP_ST   = 3'd1,
    IC_FP_ALU  = 3'd2,
    IC_INT_ALU = 3'd3,
    IC_BRANCH  = 3'd4
  } iclass_e;

  typedef enum logic [1:0] {
    TR_IDLE  = 2'd0,
    TR_ISSUE = 2'd1,
    TR_STALL = 2'd2,
    TR_FLUSH = 2'd3
  } trace_e;

  // how a source operand is consumed
  typedef enum logic [1:0] {
    RL_NONE   = 2'd0,
    RL_INT    = 2'd1,
    RL_FPALU  = 2'd2,
    RL_STDATA = 2'd3
  } role_e;

  // minimum gap (cycles) a consumer role must keep after a producer class
  function automatic logic [LAT_W-1:0] pair_latency(iclass_e prod, role_e role);
    logic [LAT_W-1:0] l;
    l = '0;
    unique case (prod)
      IC_FP_ALU:  l = (role == RL_FPALU) ? 2'd3 : (role == RL_STDATA) ? 2'd2 : 2'd0;
      IC_FP_LD:   l = (role == RL_FPALU) ? 2'd1 : 2'd0;
      IC_INT_ALU: l = (role == RL_INT) ? 2'd1 : 2'd0;
      default:    l = '0;
    endcase
    return l;
  endfunction

  function automatic logic [LAT_W-1:0] remaining(logic [LAT_W-1:0] lat, logic [LAT_W-1:0] age);
    return (lat > age) ? (lat - age) : '0;
  endfunction

  function automatic role_e src1_role(iclass_e c);
    unique case (c)
      IC_FP_ALU:                              return RL_FPALU;
      IC_FP_LD, IC_FP_ST, IC_INT_ALU, IC_BRANCH: return RL_INT;
      default:                                return RL_NONE;
    endcase
  endfunction

  function automatic role_e src2_role(iclass_e c);
    unique case (c)
      IC_FP_ALU:             return RL_FPALU;
      IC_FP_ST:              return RL_STDATA;
      IC_INT_ALU, IC_BRANCH: return RL_INT;
      default:               return RL_NONE;
    endcase
  endfunction

  function automatic logic writes_fp(iclass_e c);
    return (c == IC_FP_LD) || (c == IC_FP_ALU);
  endfunction

  function automatic logic writes_int(iclass_e c);
    return (c == IC_INT_ALU);
  endfunction

  function automatic logic [LAT_W-1:0] max2(logic [LAT_W-1:0] a, logic [LAT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/iil_scoreboard.sv
module iil_scoreboard
  import iil_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter bit SKIP_ZERO = 1'b0,
  localparam int NREG     = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  iclass_e          wr_cls,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [IDX_W-1:0] rd1_idx,
  output logic             rd0_busy,
  output iclass_e          rd0_cls,
  output logic [LAT_W-1:0] rd0_age,
  output logic             rd1_busy,
  output iclass_e          rd1_cls,
  output logic [LAT_W-1:0] rd1_age
);

  logic [NREG-1:0]  valid_q;
  iclass_e          cls_q [NREG];
  logic [LAT_W-1:0] age_q [NREG];

  // write accepted after the zero-register filter
  logic wr_ok;
  assign wr_ok = wr_en && !(SKIP_ZERO && (wr_idx == '0));

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        cls_q[g]   <= IC_FP_LD;
        age_q[g]   <= '1;
      end else if (wr_ok && (wr_idx == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
        cls_q[g]   <= wr_cls;
        age_q[g]   <= '0;
      end else if (age_q[g] != '1) begin
        age_q[g]   <= age_q[g] + 1'b1;
      end
    end
  end

  assign rd0_busy = valid_q[rd0_idx] && !(SKIP_ZERO && (rd0_idx == '0));
  assign rd0_cls  = cls_q[rd0_idx];
  assign rd0_age  = age_q[rd0_idx];
  assign rd1_busy = valid_q[rd1_idx] && !(SKIP_ZERO && (rd1_idx == '0));
  assign rd1_cls  = cls_q[rd1_idx];
  assign rd1_age  = age_q[rd1_idx];

  // R9: a new writer restarts the entry regardless of the older producer
  p_fresh_age_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (valid_q[$past(wr_idx)] && (age_q[$past(wr_idx)] == '0)));

  if (SKIP_ZERO) begin : g_zero_chk
    // R8: register zero of this file never becomes busy
    p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q[0]);
  end

endmodule

// File: rtl/iil_hazard_calc.sv
module iil_hazard_calc
  import iil_pkg::*;
(
  input  iclass_e          cons_cls,
  input  logic             fp0_busy,
  input  iclass_e          fp0_cls,
  input  logic [LAT_W-1:0] fp0_age,
  input  logic             fp1_busy,
  input  iclass_e          fp1_cls,
  input  logic [LAT_W-1:0] fp1_age,
  input  logic             in0_busy,
  input  iclass_e          in0_cls,
  input  logic [LAT_W-1:0] in0_age,
  input  logic             in1_busy,
  input  iclass_e          in1_cls,
  input  logic [LAT_W-1:0] in1_age,
  output logic [LAT_W-1:0] need1,
  output logic [LAT_W-1:0] need2,
  output logic [LAT_W-1:0] need
);

  function automatic logic [LAT_W-1:0] src_need(
    role_e r,
    logic fb, iclass_e fc, logic [LAT_W-1:0] fa,
    logic ib, iclass_e ic, logic [LAT_W-1:0] ia);
    logic [LAT_W-1:0] n;
    n = '0;
    unique case (r)
      RL_INT:              n = ib ? remaining(pair_latency(ic, r), ia) : '0;
      RL_FPALU, RL_STDATA: n = fb ? remaining(pair_latency(fc, r), fa) : '0;
      default:             n = '0;
    endcase
    return n;
  endfunction

  role_e r1, r2;
  assign r1 = src1_role(cons_cls);
  assign r2 = src2_role(cons_cls);

  assign need1 = src_need(r1, fp0_busy, fp0_cls, fp0_age, in0_busy, in0_cls, in0_age);
  assign need2 = src_need(r2, fp1_busy, fp1_cls, fp1_age, in1_busy, in1_cls, in1_age);
  assign need  = max2(need1, need2);

endmodule

// File: rtl/iil_branch_ctl.sv
module iil_branch_ctl
  import iil_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  iclass_e cls,
  input  logic    taken,
  input  logic    delay_slot_en,
  output logic    flush_q
);

  logic flush_set;
  assign flush_set = fire && (cls == IC_BRANCH) && taken && !delay_slot_en;

  always_ff @(posedge clk) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_set;
  end

  // R11: a taken branch without a filled slot is followed by a flush
  p_flush_after_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (cls == IC_BRANCH) && taken && !delay_slot_en) |=> flush_q);

  // R12: in delay-slot mode no flush follows an issue
  p_no_flush_in_slot_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && delay_slot_en) |=> !flush_q);

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import iil_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 delay_slot_en,
  input  logic                 in_valid,
  input  logic [2:0]           in_class,
  input  logic [REG_IDX_W-1:0] in_src1,
  input  logic [REG_IDX_W-1:0] in_src2,
  input  logic [REG_IDX_W-1:0] in_dst,
  input  logic                 in_taken,
  output logic                 in_ready,
  output logic                 stall_o,
  output logic [1:0]           stall_cnt,
  output logic                 flush_o,
  output logic [1:0]           trace
);

  iclass_e cls;
  assign cls = iclass_e'(in_class);

  // named internal events
  logic             issue_fire;
  logic             flush_q;
  logic [LAT_W-1:0] need, need1, need2;

  logic             fp0_busy, fp1_busy, in0_busy, in1_busy;
  iclass_e          fp0_cls, fp1_cls, in0_cls, in1_cls;
  logic [LAT_W-1:0] fp0_age, fp1_age, in0_age, in1_age;

  iil_scoreboard #(.IDX_W(REG_IDX_W), .SKIP_ZERO(1'b0)) u_fp_sb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(issue_fire && writes_fp(cls)), .wr_idx(in_dst), .wr_cls(cls),
    .rd0_idx(in_src1), .rd1_idx(in_src2),
    .rd0_busy(fp0_busy), .rd0_cls(fp0_cls), .rd0_age(fp0_age),
    .rd1_busy(fp1_busy), .rd1_cls(fp1_cls), .rd1_age(fp1_age)
  );

  iil_scoreboard #(.IDX_W(REG_IDX_W), .SKIP_ZERO(1'b1)) u_int_sb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(issue_fire && writes_int(cls)), .wr_idx(in_dst), .wr_cls(cls),
    .rd0_idx(in_src1), .rd1_idx(in_src2),
    .rd0_busy(in0_busy), .rd0_cls(in0_cls), .rd0_age(in0_age),
    .rd1_busy(in1_busy), .rd1_cls(in1_cls), .rd1_age(in1_age)
  );

  iil_hazard_calc u_calc (
    .cons_cls(cls),
    .fp0_busy(fp0_busy), .fp0_cls(fp0_cls), .fp0_age(fp0_age),
    .fp1_busy(fp1_busy), .fp1_cls(fp1_cls), .fp1_age(fp1_age),
    .in0_busy(in0_busy), .in0_cls(in0_cls), .in0_age(in0_age),
    .in1_busy(in1_busy), .in1_cls(in1_cls), .in1_age(in1_age),
    .need1(need1), .need2(need2), .need(need)
  );

  iil_branch_ctl u_br (
    .clk(clk), .rst_n(rst_n), .fire(issue_fire), .cls(cls),
    .taken(in_taken), .delay_slot_en(delay_slot_en), .flush_q(flush_q)
  );

  assign in_ready   = !flush_q && (need == '0);
  assign issue_fire = in_valid && in_ready;
  assign stall_o    = in_valid && !flush_q && (need != '0);
  assign stall_cnt  = need;
  assign flush_o    = flush_q;

  trace_e tr;
  always_comb begin
    if (flush_q)        tr = TR_FLUSH;
    else if (!in_valid) tr = TR_IDLE;
    else if (in_ready)  tr = TR_ISSUE;
    else                tr = TR_STALL;
  end
  assign trace = tr;

  logic [3*REG_IDX_W+4:0] in_pack;
  assign in_pack = {in_class, in_src1, in_src2, in_dst, in_taken};

  // R13: a held instruction sees its remaining wait shrink by one per cycle
  p_countdown_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !flush_o) |=>
      (!$stable(in_pack) || !in_valid || (stall_cnt == $past(stall_cnt) - 2'd1)));

  // R11: flush lasts a single cycle
  p_flush_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

  // R11: no instruction leaves during a flush cycle
  p_no_issue_in_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (trace == 2'd3) && !in_ready);

endmodule

// File: tb/issue_interlock_tb_top.sv
module issue_interlock_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       delay_slot_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] in_class = 3'd0;
  logic [4:0] in_src1 = 5'd0, in_src2 = 5'd0, in_dst = 5'd0;
  logic       in_taken = 1'b0;
  logic       in_ready, stall_o, flush_o;
  logic [1:0] stall_cnt, trace;

  always #10 clk = ~clk;

  issue_interlock dut_i (
    .clk(clk), .rst_n(rst_n), .delay_slot_en(delay_slot_en),
    .in_valid(in_valid), .in_class(in_class), .in_src1(in_src1),
    .in_src2(in_src2), .in_dst(in_dst), .in_taken(in_taken),
    .in_ready(in_ready), .stall_o(stall_o), .stall_cnt(stall_cnt),
    .flush_o(flush_o), .trace(trace)
  );

  int n_vec = 0, n_bad = 0;
  int g_waits, g_first, g_flushes, g_stall_tr;
  bit done = 0;

  task automatic chk(input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // offer one instruction and hold it until it issues
  task automatic send(input int c, input int a, input int b, input int d, input bit t);
    int w;
    w = 0; g_first = -1; g_flushes = 0; g_stall_tr = 1;
    @(negedge clk);
    in_valid = 1'b1; in_class = 3'(c); in_src1 = 5'(a); in_src2 = 5'(b);
    in_dst = 5'(d); in_taken = t;
    #1;
    while (!in_ready && w < 40) begin
      if (trace == 2'd3) g_flushes++;
      else begin
        if (g_first < 0) g_first = int'(stall_cnt);
        if (trace != 2'd2 || !stall_o) g_stall_tr = 0;
      end
      w++;
      @(negedge clk); #1;
    end
    if (w >= 40) chk("send hung", w, 0);
    g_waits = w;
  endtask

  task automatic gap(input int n);
    if (n > 0) begin
      @(negedge clk); in_valid = 1'b0;
      repeat (n - 1) @(negedge clk);
    end
  endtask

  // expected pair stall, from the requirement table
  function automatic int exp_stall(int p, int c, int g);
    int l;
    if (p == 2)      l = (c == 2) ? 3 : ((c == 1) ? 2 : 0);  // R2 R3
    else if (p == 0) l = (c == 2) ? 1 : 0;                     // R4 R5
    else             l = (c == 2) ? 0 : 1;                     // R6
    return (l > g) ? l - g : 0;                                // R7
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    int tot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 flush", int'(flush_o), 0);
    chk("R1 trace", int'(trace), 0);
    chk("R1 stall_cnt", int'(stall_cnt), 0);
    send(2, 4, 4, 6, 0);
    chk("R1 first issue waits", g_waits, 0);

    // sweep producer x consumer x gap (R2..R7, R13)
    for (int pi = 0; pi < 3; pi++) begin
      for (int c = 0; c < 5; c++) begin
        for (int g = 0; g < 4; g++) begin
          int p, e;
          p = (pi == 0) ? 0 : ((pi == 1) ? 2 : 3);
          gap(4);
          send(p, 10, 11, 5, 0);
          gap(g);
          send(c, 5, 5, 7, 0);
          e = exp_stall(p, c, g);
          chk($sformatf("R2-table p%0d c%0d g%0d (R3 R4 R5 R6 R7)", p, c, g), g_waits, e);
          if (e > 0) begin
            chk("R13 stall_cnt at first hold", g_first, e);
            chk("R13 stall trace", g_stall_tr, 1);
          end
        end
      end
    end

    // R8 integer r0 and file separation
    gap(4); send(3, 10, 11, 0, 0); send(3, 0, 0, 8, 0);
    chk("R8 int r0 no dependency", g_waits, 0);
    gap(4); send(2, 10, 11, 9, 0); send(3, 9, 9, 8, 0);
    chk("R8 FP dst vs int src", g_waits, 0);
    gap(4); send(3, 10, 11, 9, 0); send(2, 9, 9, 8, 0);
    chk("R8 int dst vs FP src", g_waits, 0);

    // R9 WAW: latest writer rules; WAR no stall
    gap(4); send(2, 10, 11, 4, 0); send(0, 12, 0, 4, 0); send(2, 4, 13, 14, 0);
    chk("R9 WAW latest writer", g_waits, 1);
    gap(4); send(1, 1, 13, 0, 0); send(3, 12, 12, 1, 0);
    chk("R9 WAR no stall", g_waits, 0);

    // R10 max over sources
    gap(4); send(0, 12, 0, 2, 0); send(2, 10, 11, 4, 0); send(2, 2, 4, 15, 0);
    chk("R10 max src2", g_waits, 3);
    gap(4); send(2, 10, 11, 4, 0); send(0, 12, 0, 2, 0); send(2, 4, 2, 15, 0);
    chk("R10 max src1", g_waits, 2);

    // R11 branch flush
    gap(4); send(4, 10, 11, 0, 1); send(3, 12, 13, 16, 0);
    chk("R11 taken flush waits", g_waits, 1);
    chk("R11 flush trace", g_flushes, 1);
    gap(4); send(4, 10, 11, 0, 0); send(3, 12, 13, 16, 0);
    chk("R11 not-taken no flush", g_waits, 0);

    // R12 delay slot mode
    gap(4); delay_slot_en = 1'b1;
    send(4, 10, 11, 0, 1); send(3, 12, 13, 16, 0);
    chk("R12 slot filled", g_waits, 0);
    delay_slot_en = 1'b0;

    // R14 unscheduled loop: 10 cycles per iteration
    gap(4); tot = 0;
    send(0, 1, 0, 0, 0);  tot += 1 + g_waits;
    send(2, 0, 2, 4, 0);  tot += 1 + g_waits;
    send(1, 1, 4, 0, 0);  tot += 1 + g_waits;
    send(3, 1, 0, 1, 0);  tot += 1 + g_waits;
    send(4, 1, 2, 0, 1);  tot += 1 + g_waits;
    send(0, 1, 0, 0, 0);  tot += g_waits;
    chk("R14 loop cycles", tot, 10);

    gap(2);
    finish_run();
  end

endmodule